// File: doc/BRIEF.md
# Link Transaction Sequencer

This block runs one complete transaction on a two-wire serial maintenance link. A host issues a read, write, terminate or link-reset request through a valid/ready port. The sequencer then orders the work of a separate frame transmitter and a separate response receiver. It also fills every gap between frames with counted idle bits driven onto the data line. Those gaps are the echo gap after each command, the pause before each busy poll, and the trailing clocks after each response. When the request is finished, the block returns a one-cycle response that carries a status code and, for a successful read, the read data sized to the request.

All link clocking is counted on `bit_tick`, a strobe that marks one link clock period. While `line_own` is high, the sequencer owns the data line and clocks one bit of logical value `line_bit` on each tick. Logical 0 is the idle level and logical 1 is the asserted (wire-low) level. When the slave answers busy, the sequencer inserts an idle gap and then sends a poll frame. The number of polls is limited; when they run out, it sends a terminate frame and reports a busy timeout. A reset request produces a fixed four-phase clocked pattern, followed by a settle wait counted in system clocks. After its own reset, the block raises its link enable, mux and level-translator controls, then flushes the link with idle clocks before it accepts the first request.

Top module: `link_txn_seq`

## Requirements
- R1: During reset, `link_enable`, `link_mux`, `link_xlat`, `req_ready`, `rsp_valid` and `line_own` are 0. After reset, the three link controls go high before the first owned tick, and exactly INIT_CLKS idle ticks are clocked before `req_ready` first rises.
- R2: Only one request is in flight. `req_ready` stays 0 from the cycle after acceptance until `rsp_valid` has pulsed, and a request held valid meanwhile is not started (no extra `tx_start`).
- R3: Between the end of each transmitted frame (`tx_done`) and the matching `rx_start`, exactly ECHO_CLKS idle ticks are clocked.
- R4: A response tag of 1 (busy) causes an idle gap of max(POLL_GAP, MIN_POLL_GAP) ticks, followed by a poll frame (`tx_op`=2) to the same slave. For a read, the poll expects the same number of data bytes.
- R5: At most MAX_BUSY polls are sent. A further busy answer leads to the same idle gap, then a terminate frame (`tx_op`=3) with `rx_bytes`=0. Status 1 (busy timeout) is then returned, whatever the terminate answer.
- R6: After every response of a read, write or terminate request, exactly PRIME_CLKS idle ticks are clocked before `rsp_valid`.
- R7: Status codes: 0 ok (tag 0), 1 busy timeout, 2 for tag 2, 3 for tag 3, 4 receiver timeout, 5 receiver CRC error. `rsp_valid` is a single-cycle pulse.
- R8: Tags 2 and 3 end the request at once, with no poll or terminate frame.
- R9: `rx_timeout` takes precedence over `rx_crc_err`, which takes precedence over the tag.
- R10: Request commands are 0 read, 1 write, 2 terminate, 3 reset. Transmit ops are 0 read, 1 write, 2 poll, 3 terminate. Size codes 0/1/2 mean 1/2/4 bytes; a read expects that many bytes. The read data keeps only the low bytes of the size, and it is 0 for any other outcome.
- R11: A reset request clocks PRE_BRK idle ticks, then BRK_CLKS asserted ticks, then ECHO_CLKS + POST_BRK idle ticks.
- R12: After the last reset tick, exactly SETTLE_CYC system clocks pass with the line released before `rsp_valid` with status 0.
- R13: Only cycles with `bit_tick` high count as link clocks; tick spacing does not change any count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One pulse per link clock period |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted when both high |
| req_cmd | input | 2 | 0 read, 1 write, 2 terminate, 3 link reset |
| req_slave | input | SLV_W | Target slave id |
| req_addr | input | ADDR_W | Target address |
| req_size | input | 2 | 0 byte, 1 half, 2 word |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Single-cycle completion pulse |
| rsp_status | output | 3 | Completion status code |
| rsp_rdata | output | DATA_W | Read data, size masked |
| tx_start | output | 1 | Start the frame transmitter |
| tx_op | output | 2 | Frame kind |
| tx_slave | output | SLV_W | Frame slave id |
| tx_addr | output | ADDR_W | Frame address |
| tx_size | output | 2 | Frame size code |
| tx_wdata | output | DATA_W | Frame write data |
| tx_done | input | 1 | Transmitter finished the frame |
| rx_start | output | 1 | Start the response receiver |
| rx_bytes | output | 3 | Data bytes the response carries on success |
| rx_done | input | 1 | Receiver result valid |
| rx_tag | input | 2 | Response tag |
| rx_data | input | DATA_W | Response data |
| rx_timeout | input | 1 | No start bit seen |
| rx_crc_err | input | 1 | Response check failed |
| line_own | output | 1 | Sequencer drives the data line this tick |
| line_bit | output | 1 | Logical level driven (1 = wire low) |
| link_enable | output | 1 | Link enable control |
| link_mux | output | 1 | Link mux control |
| link_xlat | output | 1 | Level translator control |

## Verification
The hardest state to reach is retry exhaustion. The slave must answer busy to the first frame and to every poll after it, and the terminate answer must still be ignored. The bench's scripted receiver answers busy for a chosen number of responses, and it sweeps that number from one to two past the poll limit. With this sweep, the last poll before the limit, the limit itself, a terminate answered with an acknowledge and a terminate answered busy all occur. Every gap is measured as a count of owned ticks, under both a dense and a sparse tick pattern.

// File: rtl/link_seq_pkg.sv
package link_seq_pkg;

  typedef enum logic [1:0] {CMD_READ = 2'd0, CMD_WRITE = 2'd1, CMD_TERM = 2'd2, CMD_RESET = 2'd3} cmd_e;
  typedef enum logic [1:0] {OP_READ = 2'd0, OP_WRITE = 2'd1, OP_POLL = 2'd2, OP_TERM = 2'd3} op_e;
  typedef enum logic [1:0] {TAG_ACK = 2'd0, TAG_BUSY = 2'd1, TAG_ERRA = 2'd2, TAG_ERRC = 2'd3} tag_e;
  typedef enum logic [2:0] {
    ST_OK = 3'd0, ST_BUSY_TO = 3'd1, ST_ERRA = 3'd2, ST_ERRC = 3'd3, ST_MTOE = 3'd4, ST_CRC = 3'd5
  } status_e;

  typedef enum logic [4:0] {
    S_PINS, S_INIT, S_IDLE, S_SEND, S_ECHO, S_RECV, S_GAP,
    S_TSEND, S_TECHO, S_TRECV, S_PRIME, S_REPORT,
    S_BPRE, S_BLOW, S_BECHO, S_BPOST, S_SETTLE
  } state_e;

  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic line_owned(input state_e s);
    return (s == S_INIT) || (s == S_ECHO) || (s == S_GAP) || (s == S_TECHO) ||
           (s == S_PRIME) || (s == S_BPRE) || (s == S_BLOW) || (s == S_BECHO) ||
           (s == S_BPOST);
  endfunction

endpackage

// File: rtl/seq_phase_timer.sv
module seq_phase_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             tick,
  output logic             last
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                   cnt <= '0;
    else if (ld)               cnt <= ld_val;
    else if (tick && cnt != 0) cnt <= cnt - 1'b1;
  end

  assign last = tick && (cnt == CNT_W'(1));

  // R3: every counted phase is at least one tick long
  p_load_nonzero_r3: assert property (@(posedge clk) disable iff (rst) ld |-> (ld_val != '0));
  // R13: the count moves only on a tick
  p_hold_no_tick_r13: assert property (@(posedge clk) disable iff (rst)
    (!ld && !tick) |=> $stable(cnt));
endmodule

// File: rtl/seq_retry_ctr.sv
module seq_retry_ctr #(
  parameter int MAX_BUSY = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic exhausted
);
  localparam int RW = $clog2(MAX_BUSY + 1);
  logic [RW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  assign exhausted = (cnt == RW'(MAX_BUSY));

  p_retry_cap_r5: assert property (@(posedge clk) disable iff (rst) cnt <= RW'(MAX_BUSY));
  p_inc_guard_r5: assert property (@(posedge clk) disable iff (rst) inc |-> !exhausted);
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import link_seq_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 21,
  parameter int SLV_W      = 2,
  parameter int CNT_W      = 16,
  parameter int INIT_CLKS  = 5000,
  parameter int ECHO_CLKS  = 16,
  parameter int GAP_CLKS   = 100,
  parameter int PRIME_CLKS = 100,
  parameter int PRE_BRK    = 50,
  parameter int BRK_CLKS   = 256,
  parameter int POST_BRK   = 16000,
  parameter int SETTLE_CYC = 2000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_cmd,
  input  logic [SLV_W-1:0]  req_slave,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [2:0]        rsp_status,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              tx_start,
  output logic [1:0]        tx_op,
  output logic [SLV_W-1:0]  tx_slave,
  output logic [ADDR_W-1:0] tx_addr,
  output logic [1:0]        tx_size,
  output logic [DATA_W-1:0] tx_wdata,
  input  logic              tx_done,
  output logic              rx_start,
  output logic [2:0]        rx_bytes,
  input  logic              rx_done,
  input  logic [1:0]        rx_tag,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_timeout,
  input  logic              rx_crc_err,
  output logic              line_own,
  output logic              line_bit,
  output logic              pins_on,
  output logic              sys_count,
  output logic              t_ld,
  output logic [CNT_W-1:0]  t_val,
  input  logic              t_last,
  output logic              rc_clr,
  output logic              rc_inc,
  input  logic              rc_done
);
  localparam logic [CNT_W-1:0] INIT_C   = CNT_W'(INIT_CLKS);
  localparam logic [CNT_W-1:0] ECHO_C   = CNT_W'(ECHO_CLKS);
  localparam logic [CNT_W-1:0] GAP_C    = CNT_W'(GAP_CLKS);
  localparam logic [CNT_W-1:0] PRIME_C  = CNT_W'(PRIME_CLKS);
  localparam logic [CNT_W-1:0] PRE_C    = CNT_W'(PRE_BRK);
  localparam logic [CNT_W-1:0] BRK_C    = CNT_W'(BRK_CLKS);
  localparam logic [CNT_W-1:0] POST_C   = CNT_W'(POST_BRK);
  localparam logic [CNT_W-1:0] SETTLE_C = CNT_W'(SETTLE_CYC);
  localparam int NBYTES = DATA_W / 8;

  state_e  state, nxt;
  cmd_e    cmd_q;
  logic [1:0] size_q;
  status_e status_q;
  logic    tx_go, rx_go, accept;
  op_e     op_n;

  function automatic logic [DATA_W-1:0] keep_low(input logic [DATA_W-1:0] d, input logic [2:0] n);
    logic [DATA_W-1:0] r;
    r = d;
    for (int b = 0; b < NBYTES; b++)
      if (b >= int'(n)) r[b*8 +: 8] = 8'h00;
    return r;
  endfunction

  always_comb begin
    nxt    = state;
    t_ld   = 1'b0;
    t_val  = '0;
    tx_go  = 1'b0;
    rx_go  = 1'b0;
    op_n   = OP_READ;
    rc_clr = 1'b0;
    rc_inc = 1'b0;
    accept = 1'b0;
    case (state)
      S_PINS: begin nxt = S_INIT; t_ld = 1'b1; t_val = INIT_C; end
      S_INIT: if (t_last) nxt = S_IDLE;
      S_IDLE: if (req_valid) begin
        accept = 1'b1;
        rc_clr = 1'b1;
        if (cmd_e'(req_cmd) == CMD_RESET) begin
          nxt = S_BPRE; t_ld = 1'b1; t_val = PRE_C;
        end else begin
          nxt   = S_SEND;
          tx_go = 1'b1;
          case (cmd_e'(req_cmd))
            CMD_WRITE: op_n = OP_WRITE;
            CMD_TERM:  op_n = OP_TERM;
            default:   op_n = OP_READ;
          endcase
        end
      end
      S_SEND:  if (tx_done) begin nxt = S_ECHO; t_ld = 1'b1; t_val = ECHO_C; end
      S_ECHO:  if (t_last) begin nxt = S_RECV; rx_go = 1'b1; end
      S_RECV:  if (rx_done) begin
        t_ld = 1'b1;
        if (!rx_timeout && !rx_crc_err && tag_e'(rx_tag) == TAG_BUSY) begin
          nxt = S_GAP; t_val = GAP_C;
        end else begin
          nxt = S_PRIME; t_val = PRIME_C;
        end
      end
      S_GAP: if (t_last) begin
        tx_go = 1'b1;
        if (rc_done) begin
          nxt = S_TSEND; op_n = OP_TERM;
        end else begin
          nxt = S_SEND; op_n = OP_POLL; rc_inc = 1'b1;
        end
      end
      S_TSEND:  if (tx_done) begin nxt = S_TECHO; t_ld = 1'b1; t_val = ECHO_C; end
      S_TECHO:  if (t_last) begin nxt = S_TRECV; rx_go = 1'b1; end
      S_TRECV:  if (rx_done) begin nxt = S_PRIME; t_ld = 1'b1; t_val = PRIME_C; end
      S_PRIME:  if (t_last) nxt = S_REPORT;
      S_REPORT: nxt = S_IDLE;
      S_BPRE:   if (t_last) begin nxt = S_BLOW;   t_ld = 1'b1; t_val = BRK_C; end
      S_BLOW:   if (t_last) begin nxt = S_BECHO;  t_ld = 1'b1; t_val = ECHO_C; end
      S_BECHO:  if (t_last) begin nxt = S_BPOST;  t_ld = 1'b1; t_val = POST_C; end
      S_BPOST:  if (t_last) begin nxt = S_SETTLE; t_ld = 1'b1; t_val = SETTLE_C; end
      S_SETTLE: if (t_last) nxt = S_REPORT;
      default:  nxt = S_PINS;
    endcase
  end

  // Values the next frame uses, taken from the request on the accepting cycle
  cmd_e       cmd_n;
  logic [1:0] size_n;
  assign cmd_n  = accept ? cmd_e'(req_cmd) : cmd_q;
  assign size_n = accept ? req_size : size_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_PINS;
      pins_on   <= 1'b0;
      line_own  <= 1'b0;
      line_bit  <= 1'b0;
      tx_start  <= 1'b0;
      rx_start  <= 1'b0;
      tx_op     <= 2'd0;
      rx_bytes  <= 3'd0;
      cmd_q     <= CMD_READ;
      size_q    <= 2'd0;
      tx_slave  <= '0;
      tx_addr   <= '0;
      tx_wdata  <= '0;
      status_q  <= ST_OK;
      rsp_rdata <= '0;
    end else begin
      state    <= nxt;
      line_own <= line_owned(nxt);
      line_bit <= (nxt == S_BLOW);
      tx_start <= tx_go;
      rx_start <= rx_go;
      if (state == S_PINS) pins_on <= 1'b1;
      if (accept) begin
        cmd_q     <= cmd_e'(req_cmd);
        size_q    <= req_size;
        tx_slave  <= req_slave;
        tx_addr   <= req_addr;
        tx_wdata  <= req_wdata;
        status_q  <= ST_OK;
        rsp_rdata <= '0;
      end
      if (tx_go) begin
        tx_op <= op_n;
        if (op_n == OP_READ || (op_n == OP_POLL && cmd_n == CMD_READ))
          rx_bytes <= size_bytes(size_n);
        else
          rx_bytes <= 3'd0;
        if (op_n == OP_TERM && state == S_GAP) status_q <= ST_BUSY_TO;
      end
      if (state == S_RECV && rx_done) begin
        if (rx_timeout)      status_q <= ST_MTOE;
        else if (rx_crc_err) status_q <= ST_CRC;
        else begin
          case (tag_e'(rx_tag))
            TAG_ACK: begin
              status_q <= ST_OK;
              if (cmd_q == CMD_READ) rsp_rdata <= keep_low(rx_data, size_bytes(size_q));
            end
            TAG_ERRA: status_q <= ST_ERRA;
            TAG_ERRC: status_q <= ST_ERRC;
            default:  ;
          endcase
        end
      end
    end
  end

  assign tx_size    = size_q;
  assign req_ready  = (state == S_IDLE);
  assign rsp_valid  = (state == S_REPORT);
  assign rsp_status = status_q;
  assign sys_count  = (state == S_SETTLE);

  p_stall_r2: assert property (@(posedge clk) disable iff (rst) rsp_valid |=> req_ready);
  p_busy_no_ready_r2: assert property (@(posedge clk) disable iff (rst) tx_start |-> !req_ready);
  p_frame_excl_r3: assert property (@(posedge clk) disable iff (rst) !(tx_start && rx_start));
  p_rsp_pulse_r7: assert property (@(posedge clk) disable iff (rst) rsp_valid |=> !rsp_valid);
  p_pins_first_r1: assert property (@(posedge clk) disable iff (rst) line_own |-> pins_on);
  p_low_owned_r11: assert property (@(posedge clk) disable iff (rst) line_bit |-> line_own);
endmodule

// File: rtl/link_txn_seq.sv
module link_txn_seq
  import link_seq_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 21,
  parameter int SLV_W        = 2,
  parameter int INIT_CLKS    = 5000,
  parameter int ECHO_CLKS    = 16,
  parameter int POLL_GAP     = 100,
  parameter int MIN_POLL_GAP = 21,
  parameter int PRIME_CLKS   = 100,
  parameter int MAX_BUSY     = 100,
  parameter int PRE_BRK      = 50,
  parameter int BRK_CLKS     = 256,
  parameter int POST_BRK     = 16000,
  parameter int SETTLE_CYC   = 2000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_cmd,
  input  logic [SLV_W-1:0]  req_slave,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [2:0]        rsp_status,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              tx_start,
  output logic [1:0]        tx_op,
  output logic [SLV_W-1:0]  tx_slave,
  output logic [ADDR_W-1:0] tx_addr,
  output logic [1:0]        tx_size,
  output logic [DATA_W-1:0] tx_wdata,
  input  logic              tx_done,
  output logic              rx_start,
  output logic [2:0]        rx_bytes,
  input  logic              rx_done,
  input  logic [1:0]        rx_tag,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_timeout,
  input  logic              rx_crc_err,
  output logic              line_own,
  output logic              line_bit,
  output logic              link_enable,
  output logic              link_mux,
  output logic              link_xlat
);
  localparam int GAP_USE = max2(POLL_GAP, MIN_POLL_GAP);
  localparam int MAXC    = max2(max2(max2(INIT_CLKS, ECHO_CLKS), max2(GAP_USE, PRIME_CLKS)),
                                max2(max2(PRE_BRK, BRK_CLKS), max2(POST_BRK, SETTLE_CYC)));
  localparam int CNT_W   = $clog2(MAXC + 1);

  logic             t_ld, t_last, tick_eff, sys_count, pins_on;
  logic [CNT_W-1:0] t_val;
  logic             rc_clr, rc_inc, rc_done;

  assign tick_eff    = sys_count | bit_tick;
  assign link_enable = pins_on;
  assign link_mux    = pins_on;
  assign link_xlat   = pins_on;

  seq_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .ld(t_ld), .ld_val(t_val), .tick(tick_eff), .last(t_last)
  );

  seq_retry_ctr #(.MAX_BUSY(MAX_BUSY)) u_retry (
    .clk(clk), .rst(rst), .clr(rc_clr), .inc(rc_inc), .exhausted(rc_done)
  );

  seq_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SLV_W(SLV_W), .CNT_W(CNT_W),
    .INIT_CLKS(INIT_CLKS), .ECHO_CLKS(ECHO_CLKS), .GAP_CLKS(GAP_USE),
    .PRIME_CLKS(PRIME_CLKS), .PRE_BRK(PRE_BRK), .BRK_CLKS(BRK_CLKS),
    .POST_BRK(POST_BRK), .SETTLE_CYC(SETTLE_CYC)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd), .req_slave(req_slave),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_rdata(rsp_rdata),
    .tx_start(tx_start), .tx_op(tx_op), .tx_slave(tx_slave), .tx_addr(tx_addr),
    .tx_size(tx_size), .tx_wdata(tx_wdata), .tx_done(tx_done),
    .rx_start(rx_start), .rx_bytes(rx_bytes), .rx_done(rx_done), .rx_tag(rx_tag),
    .rx_data(rx_data), .rx_timeout(rx_timeout), .rx_crc_err(rx_crc_err),
    .line_own(line_own), .line_bit(line_bit), .pins_on(pins_on), .sys_count(sys_count),
    .t_ld(t_ld), .t_val(t_val), .t_last(t_last),
    .rc_clr(rc_clr), .rc_inc(rc_inc), .rc_done(rc_done)
  );

  // R4: a poll always goes to the slave of the accepted request
  p_poll_same_slave_r4: assert property (@(posedge clk) disable iff (rst)
    (tx_start && tx_op == 2'd2) |-> $stable(tx_slave));
endmodule

// File: tb/link_txn_seq_test.sv
`timescale 1ns/1ps
module link_txn_seq_test;
  localparam int DW = 32, AW = 21, SW = 2;
  localparam int INIT = 12, ECHO = 4, GAPP = 8, MINGAP = 21, PRIME = 6, MAXB = 3;
  localparam int PRE = 5, BRK = 8, POST = 20, SETTLE = 10;
  localparam int GAPX = (GAPP > MINGAP) ? GAPP : MINGAP;

  logic clk = 0, rst = 1, bit_tick = 0;
  logic req_valid = 0, req_ready;
  logic [1:0] req_cmd = 0, req_size = 0;
  logic [SW-1:0] req_slave = 0;
  logic [AW-1:0] req_addr = 0;
  logic [DW-1:0] req_wdata = 0;
  logic rsp_valid; logic [2:0] rsp_status; logic [DW-1:0] rsp_rdata;
  logic tx_start; logic [1:0] tx_op; logic [SW-1:0] tx_slave; logic [AW-1:0] tx_addr;
  logic [1:0] tx_size; logic [DW-1:0] tx_wdata; logic tx_done = 0;
  logic rx_start; logic [2:0] rx_bytes; logic rx_done = 0; logic [1:0] rx_tag = 0;
  logic [DW-1:0] rx_data = 0; logic rx_timeout = 0, rx_crc_err = 0;
  logic line_own, line_bit, link_enable, link_mux, link_xlat;

  always #2.5 clk = ~clk;

  link_txn_seq #(.DATA_W(DW), .ADDR_W(AW), .SLV_W(SW), .INIT_CLKS(INIT), .ECHO_CLKS(ECHO),
    .POLL_GAP(GAPP), .MIN_POLL_GAP(MINGAP), .PRIME_CLKS(PRIME), .MAX_BUSY(MAXB),
    .PRE_BRK(PRE), .BRK_CLKS(BRK), .POST_BRK(POST), .SETTLE_CYC(SETTLE)) uut (.*);

  int checks = 0, fails = 0, tick_mode = 0, cyc = 0;
  // receiver script
  int busy_left = 0, fin_tag = 0, fin_to = 0, fin_crc = 0; logic [DW-1:0] rdat = 0;
  // monitor state
  int idle_run = 0, n_tx = 0, n_dp = 0, n_term = 0, gap_bad = 0, echo_bad = 0;
  int low_cnt = 0, pre_idle = 0, at_idle = 0, at_noown = 0, noown = 0;
  int init_seen = 0, init_idle = 0, pin_bad = 0, first_rxb = -1, last_rxb = 0, last_op = 0;
  int dp_slave_bad = 0;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  initial forever begin
    @(posedge clk); #1;
    cyc++;
    bit_tick = (tick_mode == 0) ? 1'b1 : (cyc % 3 == 0);
  end

  initial forever begin
    @(negedge clk); tx_done = 0;
    if (tx_start) begin repeat (2) @(negedge clk); tx_done = 1; end
  end

  initial forever begin
    @(negedge clk); rx_done = 0;
    if (rx_start) begin
      repeat (2) @(negedge clk);
      rx_done = 1;
      if (busy_left > 0) begin
        busy_left--; rx_tag = 2'd1; rx_timeout = 0; rx_crc_err = 0; rx_data = 32'h5a5a5a5a;
      end else begin
        rx_tag = 2'(fin_tag); rx_timeout = fin_to[0]; rx_crc_err = fin_crc[0]; rx_data = rdat;
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (rst) begin
      idle_run = 0; init_seen = 0; noown = 0;
    end else begin
      if (line_own && !link_enable) pin_bad++;
      if (tx_start) begin
        n_tx++; last_op = tx_op;
        if (tx_op == 2) begin
          n_dp++;
          if (idle_run != GAPX) gap_bad++;
          if (tx_slave != req_slave) dp_slave_bad++;
        end
        if (tx_op == 3 && n_dp > 0) begin n_term++; if (idle_run != GAPX) gap_bad++; end
        idle_run = 0;
      end
      if (rx_start) begin
        if (idle_run != ECHO) echo_bad++;
        if (first_rxb < 0) first_rxb = rx_bytes;
        last_rxb = rx_bytes; idle_run = 0;
      end
      if (rsp_valid) begin at_idle = idle_run; at_noown = noown; idle_run = 0; end
      if (!init_seen && req_ready) begin init_seen = 1; init_idle = idle_run; end
      if (line_own && bit_tick) begin
        if (line_bit) begin
          if (low_cnt == 0) begin pre_idle = idle_run; idle_run = 0; end
          low_cnt++;
        end else idle_run++;
      end
      if (line_own) noown = 0; else noown++;
    end
  end

  task automatic do_reset();
    rst = 1; req_valid = 0;
    repeat (3) @(negedge clk);
    chk(req_ready == 0 && rsp_valid == 0 && line_own == 0, "R1", "ready/rsp/own in reset", req_ready, 0);
    chk(link_enable == 0 && link_mux == 0 && link_xlat == 0, "R1", "pins in reset", link_enable, 0);
    @(posedge clk); #1 rst = 0; pin_bad = 0;
    while (!init_seen) @(negedge clk);
    #1;
    chk(init_idle == INIT, "R1", "init idle ticks", init_idle, INIT);
    chk(link_enable && link_mux && link_xlat && pin_bad == 0, "R1", "pins high before clocks", pin_bad, 0);
  endtask

  // one request, returns nothing; checks status, data, gaps
  task automatic txn(input int cmd, input int size, input int slave, input logic [DW-1:0] wd,
                     input int busy, input int tag, input int to, input int crc,
                     input logic [DW-1:0] rd, input int hold);
    int exp_st, exp_dp, exp_term, nb, stall_bad, exp_rxb;
    logic [DW-1:0] exp_rd;
    longint mask;
    busy_left = busy; fin_tag = tag; fin_to = to; fin_crc = crc; rdat = rd;
    while (!req_ready) @(negedge clk);
    #1;
    n_tx = 0; n_dp = 0; n_term = 0; gap_bad = 0; echo_bad = 0; low_cnt = 0; first_rxb = -1;
    dp_slave_bad = 0; stall_bad = 0;
    req_valid = 1; req_cmd = 2'(cmd); req_size = 2'(size); req_slave = SW'(slave);
    req_addr = AW'(slave * 4099 + size); req_wdata = wd;
    @(negedge clk);
    if (hold) begin req_cmd = 2'd1; end else req_valid = 0;
    while (!rsp_valid) begin
      if (req_ready) stall_bad++;
      @(negedge clk);
    end
    #1;
    nb = (size == 0) ? 1 : (size == 1) ? 2 : 4;
    mask = (64'd1 << (8 * nb)) - 1;
    if (cmd == 3) begin
      chk(rsp_status == 0, "R12", "reset status", rsp_status, 0);
      chk(pre_idle == PRE, "R11", "pre-reset idle", pre_idle, PRE);
      chk(low_cnt == BRK, "R11", "asserted ticks", low_cnt, BRK);
      chk(at_idle == ECHO + POST, "R11", "post-reset idle", at_idle, ECHO + POST);
      chk(at_noown == SETTLE, "R12", "settle cycles", at_noown, SETTLE);
      chk(n_tx == 0, "R11", "no frames in reset", n_tx, 0);
    end else begin
      exp_term = (busy > MAXB);
      exp_dp   = exp_term ? MAXB : busy;
      if (exp_term) exp_st = 1;
      else if (to) exp_st = 4;
      else if (crc) exp_st = 5;
      else exp_st = tag;
      exp_rd = (cmd == 0 && exp_st == 0) ? DW'(longint'(rd) & mask) : '0;
      exp_rxb = (cmd == 0) ? nb : 0;
      chk(rsp_status == 3'(exp_st), exp_term ? "R5" : (to || crc) ? "R9" : "R7", "status",
          rsp_status, exp_st);
      chk(rsp_rdata == exp_rd, "R10", "read data", rsp_rdata, exp_rd);
      chk(n_dp == exp_dp, (tag >= 2) ? "R8" : "R4", "poll count", n_dp, exp_dp);
      chk(n_term == exp_term, "R5", "terminate frames", n_term, exp_term);
      chk(n_tx == 1 + exp_dp + exp_term, "R2", "frames per request", n_tx, 1 + exp_dp + exp_term);
      chk(gap_bad == 0 && dp_slave_bad == 0, "R4", "poll gap/slave errors", gap_bad, 0);
      chk(echo_bad == 0, "R3", "echo gap errors", echo_bad, 0);
      chk(first_rxb == exp_rxb, "R10", "expected bytes", first_rxb, exp_rxb);
      if (exp_term) chk(last_rxb == 0 && last_op == 3, "R5", "terminate frame bytes", last_rxb, 0);
      chk(at_idle == PRIME, "R6", "trailing idle", at_idle, PRIME);
    end
    chk(stall_bad == 0, "R2", "ready low while busy", stall_bad, 0);
  endtask

  task automatic suite();
    int k;
    do_reset();
    for (int s = 0; s < 3; s++)
      txn(0, s, s + 1, 0, 0, 0, 0, 0, 32'hA1B2C3D4 + s, 0);                   // R10 sizes
    txn(1, 2, 2, 32'hCAFEF00D, 0, 0, 0, 0, 32'h12345678, 0);                 // R10 write
    txn(2, 0, 3, 0, 0, 0, 0, 0, 32'hFFFFFFFF, 0);                             // R10 terminate
    for (int b = 1; b <= MAXB + 2; b++) txn(0, 1, b % 4, 0, b, 0, 0, 0, 32'h0000BEEF, 0); // R4 R5
    txn(1, 0, 1, 32'h77, 0, 2, 0, 0, 0, 0);                                   // R8 tag 2
    txn(0, 2, 2, 0, 0, 3, 0, 0, 32'h1, 0);                                    // R8 tag 3
    txn(0, 2, 0, 0, 1, 3, 0, 0, 32'h1, 0);                                    // R8 after one poll
    txn(0, 2, 1, 0, 0, 2, 1, 1, 32'h9, 0);                                    // R9 timeout first
    txn(0, 0, 1, 0, 0, 3, 0, 1, 32'h9, 0);                                    // R9 crc over tag
    txn(3, 0, 0, 0, 0, 0, 0, 0, 0, 0);                                        // R11 R12
    // R2: request held valid during a transaction is not started early
    txn(0, 1, 2, 0, 1, 0, 0, 0, 32'h00AB00CD, 1);
    k = 0;
    while (!req_ready) @(negedge clk);
    @(negedge clk); req_valid = 0;
    while (!rsp_valid) begin @(negedge clk); k++; if (k > 2000) break; end
    #1;
    chk(rsp_valid == 1 && rsp_status == 0, "R2", "held request runs after", rsp_status, 0);
    chk(at_idle == PRIME, "R6", "held request trailing idle", at_idle, PRIME);
  endtask

  initial begin
    tick_mode = 0; suite();   // R13 dense ticks
    tick_mode = 1; suite();   // R13 sparse ticks
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule